// File: doc/BRIEF.md
# UART Receive Error State Keeper

This block holds the receiver-enable flag and three sticky receive error flags (parity, framing, overrun) for a memory-mapped serial port. Software reads all four through one read-only status word. It changes them only through a write-only strobe word, in which each bit either sets or clears a single flag. A driver therefore never needs a read-modify-write sequence, and an interrupt handler can acknowledge several errors with one store.

The receive shifter, which lies outside this block, reports each detected error as a one-cycle pulse. A pulse is latched only when its error class is enabled in the mode word. The error interrupt stays high as long as any latched error flag is set. The receiver enable is a two-state machine: `RX_OFF` is the reset state. It moves to `RX_ON` on the enable strobe and returns to `RX_OFF` on the disable strobe. The disable strobe wins when both arrive in the same write. A driver programs the mode and baud settings first and then issues the enable strobe.

Top module: `uart_err_state`

## Requirements
- R1: After reset the status word reads all zero, `err_irq` is low and `rx_enable` is low. The mode enables are all off.
- R2: In a strobe write, bit 1 moves the receiver to enabled (status bit 15 and `rx_enable` high) and bit 0 moves it to disabled. When both bits are 1, the receiver ends up disabled.
- R3: A parity pulse sets status bit 16 only while mode bit 18 is 1. With that mode bit at 0 the pulse leaves the status word unchanged.
- R4: A framing pulse sets status bit 17 only while mode bit 17 is 1. Otherwise the pulse leaves the status word unchanged.
- R5: An overrun pulse sets status bit 19 only while mode bit 19 is 1. Otherwise the pulse leaves the status word unchanged.
- R6: An error flag stays set until a strobe write clears it: bit 2 clears parity, bit 3 clears framing, bit 5 clears overrun. One write with bits 2, 3 and 5 all set clears all three.
- R7: When an enabled error pulse and that flag's clear strobe arrive in the same cycle, the flag is set afterwards.
- R8: `err_irq` is high exactly when at least one of status bits 16, 17 or 19 is set.
- R9: Status bits other than 15, 16, 17 and 19 always read 0. Strobe bits other than 0, 1, 2, 3 and 5 have no effect on any flag.
- R10: Turning a mode enable off does not clear a flag that is already set.
- R11: Every flag change appears on the outputs on the clock edge that samples the strobe write or the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 32 | Mode word: bit 17 framing enable, bit 18 parity enable, bit 19 overrun enable |
| flag_wr | input | 1 | Write strobe for the set/clear word |
| flag_wdata | input | 32 | Set/clear strobe word |
| par_err_pulse | input | 1 | One-cycle parity error report from the receiver |
| frm_err_pulse | input | 1 | One-cycle framing error report from the receiver |
| ovr_err_pulse | input | 1 | One-cycle overrun error report from the receiver |
| status_rdata | output | 32 | Read-only status word |
| rx_enable | output | 1 | Receiver enable |
| err_irq | output | 1 | Error interrupt request |

## Verification
Several rules are checked by the assertions on every cycle: the interrupt follows the error flags, the clear strobe beats the set strobe on the receiver enable, a flag holds its value when no strobe or pulse acts on it, a cleared flag falls unless a pulse arrives at the same time, and the unused status bits stay at zero. Other behaviour can only be shown by the bench's scenarios. These are the gating by the mode enables with their particular bit positions, the clearing of all three flags in one write, the priority of a pulse over a clear, the lack of effect of unused strobe bits, and a flag that outlives its own enable.

// File: rtl/uart_err_state_pkg.sv
package uart_err_state_pkg;

    localparam int NUM_ERR = 3;

    // index 0 parity, 1 framing, 2 overrun
    localparam int ERR_STATUS_POS [NUM_ERR] = '{16, 17, 19};
    localparam int ERR_CLEAR_POS  [NUM_ERR] = '{2, 3, 5};
    localparam int ERR_MODE_POS   [NUM_ERR] = '{18, 17, 19};

    localparam int RXEN_STATUS_POS = 15;
    localparam int RXEN_CLEAR_POS  = 0;
    localparam int RXEN_SET_POS    = 1;

    typedef enum logic {
        RX_OFF = 1'b0,
        RX_ON  = 1'b1
    } rx_state_e;

endpackage

// File: rtl/uart_err_rx_fsm.sv
module uart_err_rx_fsm
    import uart_err_state_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_on,
    input  logic go_off,
    output logic enabled
);

    rx_state_e cur_q, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= RX_OFF;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            RX_OFF: if (go_on && !go_off) nxt = RX_ON;
            RX_ON:  if (go_off)           nxt = RX_OFF;
            default:                      nxt = RX_OFF;
        endcase
    end

    always_comb begin
        enabled = (cur_q == RX_ON);
    end

endmodule

// File: rtl/uart_err_flag.sv
module uart_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en,
    input  logic hit,
    input  logic clear,
    output logic flag
);

    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               flag_q <= 1'b0;
        else if (hit && gate_en)  flag_q <= 1'b1;
        else if (clear)           flag_q <= 1'b0;
    end

    assign flag = flag_q;

endmodule

// File: rtl/uart_err_state.sv
module uart_err_state
    import uart_err_state_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [WORD_W-1:0] mode_wdata,
    input  logic              flag_wr,
    input  logic [WORD_W-1:0] flag_wdata,
    input  logic              par_err_pulse,
    input  logic              frm_err_pulse,
    input  logic              ovr_err_pulse,
    output logic [WORD_W-1:0] status_rdata,
    output logic              rx_enable,
    output logic              err_irq
);

    logic [NUM_ERR-1:0] err_hit;
    logic [NUM_ERR-1:0] err_gate_q;
    logic [NUM_ERR-1:0] err_flag;

    assign err_hit = {ovr_err_pulse, frm_err_pulse, par_err_pulse};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_gate_q <= '0;
        end else if (mode_wr) begin
            for (int i = 0; i < NUM_ERR; i++)
                err_gate_q[i] <= mode_wdata[ERR_MODE_POS[i]];
        end
    end

    uart_err_rx_fsm u_rx_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_on   (flag_wr && flag_wdata[RXEN_SET_POS]),
        .go_off  (flag_wr && flag_wdata[RXEN_CLEAR_POS]),
        .enabled (rx_enable)
    );

    for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
        uart_err_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .gate_en (err_gate_q[g]),
            .hit     (err_hit[g]),
            .clear   (flag_wr && flag_wdata[ERR_CLEAR_POS[g]]),
            .flag    (err_flag[g])
        );
    end

    always_comb begin
        status_rdata = '0;
        status_rdata[RXEN_STATUS_POS] = rx_enable;
        for (int i = 0; i < NUM_ERR; i++)
            status_rdata[ERR_STATUS_POS[i]] = err_flag[i];
        err_irq = |err_flag;
    end

endmodule

// File: rtl/uart_err_state_chk.sv
module uart_err_state_chk
    import uart_err_state_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flag_wr,
    input logic [WORD_W-1:0] flag_wdata,
    input logic              par_err_pulse,
    input logic [WORD_W-1:0] status_rdata,
    input logic              rx_enable,
    input logic              err_irq
);

    localparam logic [WORD_W-1:0] USED_MASK =
        (WORD_W'(1) << 15) | (WORD_W'(1) << 16) | (WORD_W'(1) << 17) | (WORD_W'(1) << 19);

    a_r8_irq_follows_flags: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq == (status_rdata[16] | status_rdata[17] | status_rdata[19]));

    a_r2_clear_beats_set: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && flag_wdata[0]) |=> !rx_enable);

    a_r2_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && flag_wdata[1] && !flag_wdata[0]) |=> rx_enable);

    a_r6_parity_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rdata[16] && !(flag_wr && flag_wdata[2])) |=> status_rdata[16]);

    a_r6_parity_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && flag_wdata[2] && !par_err_pulse) |=> !status_rdata[16]);

    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rdata & ~USED_MASK) == '0);

endmodule

bind uart_err_state uart_err_state_chk #(.WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flag_wr       (flag_wr),
    .flag_wdata    (flag_wdata),
    .par_err_pulse (par_err_pulse),
    .status_rdata  (status_rdata),
    .rx_enable     (rx_enable),
    .err_irq       (err_irq)
);

// File: tb/test_uart_err_state.sv
module test_uart_err_state;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PE = 32'h0001_0000;
    localparam logic [31:0] FE = 32'h0002_0000;
    localparam logic [31:0] OE = 32'h0008_0000;
    localparam logic [31:0] RX = 32'h0000_8000;
    localparam logic [31:0] M_PAR = 32'h0004_0000;
    localparam logic [31:0] M_FRM = 32'h0002_0000;
    localparam logic [31:0] M_OVR = 32'h0008_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [31:0] mode_wdata = '0;
    logic        flag_wr = 1'b0;
    logic [31:0] flag_wdata = '0;
    logic        par_err_pulse = 1'b0;
    logic        frm_err_pulse = 1'b0;
    logic        ovr_err_pulse = 1'b0;
    logic [31:0] status_rdata;
    logic        rx_enable;
    logic        err_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_err_state i_uart_err_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_wr       (mode_wr),
        .mode_wdata    (mode_wdata),
        .flag_wr       (flag_wr),
        .flag_wdata    (flag_wdata),
        .par_err_pulse (par_err_pulse),
        .frm_err_pulse (frm_err_pulse),
        .ovr_err_pulse (ovr_err_pulse),
        .status_rdata  (status_rdata),
        .rx_enable     (rx_enable),
        .err_irq       (err_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // every driver starts and ends on a falling edge
    task automatic wr_mode(input logic [31:0] v);
        mode_wr = 1'b1; mode_wdata = v;
        @(negedge clk);
        mode_wr = 1'b0; mode_wdata = '0;
    endtask

    task automatic wr_flags(input logic [31:0] v);
        flag_wr = 1'b1; flag_wdata = v;
        @(negedge clk);
        flag_wr = 1'b0; flag_wdata = '0;
    endtask

    task automatic pulse(input logic p, input logic f, input logic o);
        par_err_pulse = p; frm_err_pulse = f; ovr_err_pulse = o;
        @(negedge clk);
        par_err_pulse = 1'b0; frm_err_pulse = 1'b0; ovr_err_pulse = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 status", status_rdata, 32'h0);
        chk("R1 irq", {31'b0, err_irq}, 32'h0);
        chk("R1 rx_enable", {31'b0, rx_enable}, 32'h0);
        pulse(1, 1, 1);
        chk("R1 enables off after reset", status_rdata, 32'h0);
    endtask

    task automatic t_rx_enable;
        wr_flags(32'h2);
        chk("R2 R11 set rx", status_rdata, RX);
        chk("R2 rx pin", {31'b0, rx_enable}, 32'h1);
        wr_flags(32'h1);
        chk("R2 clear rx", status_rdata, 32'h0);
        wr_flags(32'h2);
        wr_flags(32'h3);
        chk("R2 clear wins", status_rdata, 32'h0);
    endtask

    task automatic t_gating;
        wr_mode(M_FRM | M_OVR);
        pulse(1, 0, 0);
        chk("R3 parity ignored when off", status_rdata, 32'h0);
        wr_mode(M_PAR);
        pulse(1, 0, 0);
        chk("R3 R11 parity latched", status_rdata, PE);
        chk("R8 irq parity", {31'b0, err_irq}, 32'h1);
        pulse(0, 1, 1);
        chk("R4 R5 framing/overrun ignored when off", status_rdata, PE);
        wr_flags(32'h4);
        chk("R6 parity cleared", status_rdata, 32'h0);
        chk("R8 irq low", {31'b0, err_irq}, 32'h0);
        wr_mode(M_FRM);
        pulse(0, 1, 0);
        chk("R4 framing latched", status_rdata, FE);
        wr_mode(M_OVR);
        pulse(0, 0, 1);
        chk("R5 overrun latched", status_rdata, FE | OE);
        chk("R10 framing kept with enable off", status_rdata & FE, FE);
        wr_flags(32'h8);
        chk("R6 framing cleared alone", status_rdata, OE);
        chk("R8 irq overrun", {31'b0, err_irq}, 32'h1);
        wr_flags(32'h20);
        chk("R6 overrun cleared", status_rdata, 32'h0);
    endtask

    task automatic t_multi_clear;
        wr_mode(M_PAR | M_FRM | M_OVR);
        pulse(1, 1, 1);
        repeat (3) @(negedge clk);
        chk("R6 sticky", status_rdata, PE | FE | OE);
        wr_flags(32'hFFFF_FFD0);
        chk("R9 unused strobes no effect", status_rdata, PE | FE | OE);
        wr_flags(32'h2C);
        chk("R6 one write clears all", status_rdata, 32'h0);
        chk("R8 irq after clear", {31'b0, err_irq}, 32'h0);
    endtask

    task automatic t_collision;
        wr_mode(M_PAR | M_FRM | M_OVR);
        pulse(0, 1, 0);
        flag_wr = 1'b1; flag_wdata = 32'h2C;
        par_err_pulse = 1'b1; frm_err_pulse = 1'b1;
        @(negedge clk);
        flag_wr = 1'b0; flag_wdata = '0;
        par_err_pulse = 1'b0; frm_err_pulse = 1'b0;
        chk("R7 pulse beats clear", status_rdata, PE | FE);
        wr_flags(32'h2C);
        wr_flags(32'h2);
        pulse(1, 1, 1);
        chk("R9 only used bits", status_rdata, RX | PE | FE | OE);
        wr_flags(32'h2D);
    endtask

    initial begin
        bit done = 0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_rx_enable();
                t_gating();
                t_multi_clear();
                t_collision();
                done = 1;
            end
            begin
                repeat (5000) @(negedge clk);
                if (!done) begin
                    n_chk++; n_fail++;
                    $display("FAIL watchdog: got timeout expected completion");
                end
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule